// File: doc/BRIEF.md
# TLB Demap Command Decoder

This block turns a write to a translation buffer's demap register into a single invalidate command. The write carries an address whose bit fields name the operation and the context source, plus a side select that says whether the instruction-side or the data-side register was written. The block combines these fields with the current partition id and the primary and secondary context values. It then emits one command that names the operation, the page address, the real flag, the context id and the partition id.

Requests that name an unusable context are dropped quietly. A request with the reserved operation code is reported as an error. Commands leave through a one-entry valid/ready slot. An accepted write shows up on the outputs in the next cycle. While the slot holds a command that the consumer has not taken, `wr_ready` is low. The write side must then hold `wr_valid` and its fields until `wr_ready` rises. The slot refills in the same cycle in which the consumer drains it, so back-to-back commands cost no bubble. The error and ignore flags are plain one-cycle pulses with no handshake.

Top module: `demap_decoder`

## Requirements
- R1: The context selector is `wr_addr[5:4]`. Code 0 uses `pri_ctx` as the command context and code 3 uses context 0. This applies to page demaps (`cmd_op`=0) and context demaps (`cmd_op`=1) on both sides.
- R2: Selector code 1 uses `sec_ctx` when `wr_dside`=1 (data side). When `wr_dside`=0 (instruction side), a page or context demap with this code is ignored.
- R3: Selector code 2 causes page and context demaps to be ignored on both sides.
- R4: The operation is `wr_addr[7:6]`: 0 demaps a page, 1 demaps a context and 2 demaps the whole partition. `cmd_op` carries the same code.
- R5: A demap-all (op 2) is always issued, whatever the selector and the side. Its `cmd_ctx`, `cmd_page` and `cmd_real` are 0.
- R6: Operation code 3 produces a `req_err` pulse and no command, whatever the selector. It never raises `req_ignored`.
- R7: For a page demap, `cmd_page` is `wr_addr[63:13]` and `cmd_real` is `wr_addr[9]`. A context demap has `cmd_page`=0 and `cmd_real`=0.
- R8: `cmd_part` equals `cur_part` as sampled in the cycle the write is accepted.
- R9: An ignored request raises a `req_ignored` pulse and produces neither a command nor `req_err`.
- R10: After reset, `cmd_valid`, `req_err` and `req_ignored` are 0 and `wr_ready` is 1. Results appear in the cycle after acceptance, and the pulses last exactly one cycle.
- R11: While `cmd_valid`=1 and `cmd_ready`=0, the command fields are held stable and `wr_ready` is 0. A write presented in the cycle the held command drains is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Demap register write offered |
| wr_ready | output | 1 | Write accepted when high with wr_valid |
| wr_addr | input | 64 | Write address holding the command fields |
| wr_dside | input | 1 | 1 = data-side register, 0 = instruction-side |
| cur_part | input | 8 | Current partition id |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_op | output | 2 | 0 page, 1 context, 2 all |
| cmd_page | output | 51 | Page address for a page demap |
| cmd_real | output | 1 | Real-address flag for a page demap |
| cmd_ctx | output | 13 | Context id |
| cmd_part | output | 8 | Partition id |
| req_err | output | 1 | One-cycle pulse: reserved operation code |
| req_ignored | output | 1 | One-cycle pulse: request dropped |

## Verification
Two of the block's functions can fall in the same cycle: draining a held command and accepting the next write. The bench provokes this by stalling `cmd_ready` over a page demap while a demap-all waits at the input, and by changing `cur_part` during the stall. It then raises `cmd_ready` with the write still offered. It judges the result by checking three things: the first command stayed intact during the stall, the demap-all appears exactly one cycle later with the partition sampled at its acceptance, and the slot empties afterwards. A full sweep over side, operation, selector and real bit, with varying page and context values, covers the decode.

// File: rtl/demap_pkg.sv
package demap_pkg;
  typedef enum logic [1:0] {
    OP_PAGE = 2'd0,
    OP_CTX  = 2'd1,
    OP_ALL  = 2'd2,
    OP_BAD  = 2'd3
  } demap_op_e;

  typedef enum logic [1:0] {
    CSEL_PRI  = 2'd0,
    CSEL_SEC  = 2'd1,
    CSEL_NONE = 2'd2,
    CSEL_ZERO = 2'd3
  } ctx_sel_e;
endpackage

// File: rtl/demap_ctx_sel.sv
module demap_ctx_sel
  import demap_pkg::*;
#(
  parameter int CTX_W = 13
) (
  input  logic [1:0]       sel,
  input  logic             dside,
  input  logic [CTX_W-1:0] pri_ctx,
  input  logic [CTX_W-1:0] sec_ctx,
  output logic [CTX_W-1:0] ctx_val,
  output logic             ctx_ok
);
  always_comb begin
    ctx_val = '0;
    ctx_ok  = 1'b0;
    case (ctx_sel_e'(sel))
      CSEL_PRI: begin
        ctx_val = pri_ctx;
        ctx_ok  = 1'b1;
      end
      CSEL_SEC: begin
        // the secondary context exists only for the data side
        ctx_val = dside ? sec_ctx : '0;
        ctx_ok  = dside;
      end
      CSEL_ZERO: begin
        ctx_val = '0;
        ctx_ok  = 1'b1;
      end
      default: begin
        ctx_val = '0;
        ctx_ok  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/demap_op_decode.sv
module demap_op_decode
  import demap_pkg::*;
#(
  parameter int PAGE_W = 51,
  parameter int CTX_W  = 13
) (
  input  logic [1:0]        op_f,
  input  logic [PAGE_W-1:0] page_f,
  input  logic              real_f,
  input  logic [CTX_W-1:0]  ctx_val,
  input  logic              ctx_ok,
  output logic              issue,
  output logic              bad,
  output logic              ignored,
  output logic [1:0]        op_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              real_o,
  output logic [CTX_W-1:0]  ctx_o
);
  always_comb begin
    issue   = 1'b0;
    bad     = 1'b0;
    ignored = 1'b0;
    op_o    = op_f;
    page_o  = '0;
    real_o  = 1'b0;
    ctx_o   = '0;
    case (demap_op_e'(op_f))
      OP_PAGE: begin
        issue   = ctx_ok;
        ignored = !ctx_ok;
        page_o  = page_f;
        real_o  = real_f;
        ctx_o   = ctx_val;
      end
      OP_CTX: begin
        issue   = ctx_ok;
        ignored = !ctx_ok;
        ctx_o   = ctx_val;
      end
      OP_ALL: begin
        // partition-wide demap does not depend on the context selector
        issue = 1'b1;
      end
      default: begin
        bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/demap_cmd_slot.sv
module demap_cmd_slot #(
  parameter int PAGE_W = 51,
  parameter int CTX_W  = 13,
  parameter int PART_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_issue,
  input  logic              in_bad,
  input  logic              in_ignored,
  input  logic [1:0]        in_op,
  input  logic [PAGE_W-1:0] in_page,
  input  logic              in_real,
  input  logic [CTX_W-1:0]  in_ctx,
  input  logic [PART_W-1:0] in_part,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_op,
  output logic [PAGE_W-1:0] out_page,
  output logic              out_real,
  output logic [CTX_W-1:0]  out_ctx,
  output logic [PART_W-1:0] out_part,
  output logic              out_err,
  output logic              out_ign
);
  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_ign   <= 1'b0;
      out_op    <= '0;
      out_page  <= '0;
      out_real  <= 1'b0;
      out_ctx   <= '0;
      out_part  <= '0;
    end else begin
      out_err <= accept && in_bad;
      out_ign <= accept && in_ignored;
      if (accept) begin
        out_valid <= in_issue;
        out_op    <= in_op;
        out_page  <= in_page;
        out_real  <= in_real;
        out_ctx   <= in_ctx;
        out_part  <= in_part;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/demap_decoder.sv
module demap_decoder #(
  parameter int VA_W      = 64,
  parameter int PAGE_LSB  = 13,
  parameter int REAL_BIT  = 9,
  parameter int OP_LSB    = 6,
  parameter int CSEL_LSB  = 4,
  parameter int CTX_W     = 13,
  parameter int PART_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [VA_W-1:0]        wr_addr,
  input  logic                   wr_dside,
  input  logic [PART_W-1:0]      cur_part,
  input  logic [CTX_W-1:0]       pri_ctx,
  input  logic [CTX_W-1:0]       sec_ctx,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic [1:0]             cmd_op,
  output logic [VA_W-PAGE_LSB-1:0] cmd_page,
  output logic                   cmd_real,
  output logic [CTX_W-1:0]       cmd_ctx,
  output logic [PART_W-1:0]      cmd_part,
  output logic                   req_err,
  output logic                   req_ignored
);
  localparam int PAGE_W = VA_W - PAGE_LSB;

  logic [CTX_W-1:0]  ctx_val;
  logic              ctx_ok;
  logic              d_issue, d_bad, d_ign, d_real;
  logic [1:0]        d_op;
  logic [PAGE_W-1:0] d_page;
  logic [CTX_W-1:0]  d_ctx;
  logic              unused_addr;

  // the low address bits that carry no field
  assign unused_addr = ^wr_addr;

  demap_ctx_sel #(.CTX_W(CTX_W)) u_csel (
    .sel     (wr_addr[CSEL_LSB +: 2]),
    .dside   (wr_dside),
    .pri_ctx (pri_ctx),
    .sec_ctx (sec_ctx),
    .ctx_val (ctx_val),
    .ctx_ok  (ctx_ok)
  );

  demap_op_decode #(.PAGE_W(PAGE_W), .CTX_W(CTX_W)) u_dec (
    .op_f    (wr_addr[OP_LSB +: 2]),
    .page_f  (wr_addr[VA_W-1:PAGE_LSB]),
    .real_f  (wr_addr[REAL_BIT]),
    .ctx_val (ctx_val),
    .ctx_ok  (ctx_ok),
    .issue   (d_issue),
    .bad     (d_bad),
    .ignored (d_ign),
    .op_o    (d_op),
    .page_o  (d_page),
    .real_o  (d_real),
    .ctx_o   (d_ctx)
  );

  demap_cmd_slot #(.PAGE_W(PAGE_W), .CTX_W(CTX_W), .PART_W(PART_W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (wr_valid),
    .in_ready   (wr_ready),
    .in_issue   (d_issue),
    .in_bad     (d_bad),
    .in_ignored (d_ign),
    .in_op      (d_op),
    .in_page    (d_page),
    .in_real    (d_real),
    .in_ctx     (d_ctx),
    .in_part    (cur_part),
    .out_valid  (cmd_valid),
    .out_ready  (cmd_ready),
    .out_op     (cmd_op),
    .out_page   (cmd_page),
    .out_real   (cmd_real),
    .out_ctx    (cmd_ctx),
    .out_part   (cmd_part),
    .out_err    (req_err),
    .out_ign    (req_ignored)
  );
endmodule

// File: rtl/demap_decoder_chk.sv
module demap_decoder_chk #(
  parameter int PAGE_W = 51,
  parameter int CTX_W  = 13,
  parameter int PART_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [1:0]        op_f,
  input logic [1:0]        sel_f,
  input logic              wr_dside,
  input logic [PART_W-1:0] cur_part,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [PAGE_W-1:0] cmd_page,
  input logic              cmd_real,
  input logic [CTX_W-1:0]  cmd_ctx,
  input logic [PART_W-1:0] cmd_part,
  input logic              req_err,
  input logic              req_ignored
);
  logic acc;
  assign acc = wr_valid && wr_ready;

  // R6: reserved operation code gives an error pulse
  a_r6_bad_op_err: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_f == 2'd3 |=> req_err && !cmd_valid && !req_ignored);

  // R5 / R8: demap-all always issued with the sampled partition
  a_r5_all_issued: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_f == 2'd2 |=> cmd_valid && cmd_op == 2'd2 && cmd_ctx == '0
                            && cmd_part == $past(cur_part));

  // R2: secondary selector on the instruction side is dropped
  a_r2_iside_sec_ign: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !wr_dside && sel_f == 2'd1 && op_f[1] == 1'b0 |=> req_ignored && !cmd_valid);

  // R9: ignore and error never coincide and never carry a command
  a_r9_ign_excl: assert property (@(posedge clk) disable iff (!rst_n)
    req_ignored |-> !req_err && !cmd_valid);

  // R11: a stalled command holds its fields and blocks input
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_page)
                                && $stable(cmd_real) && $stable(cmd_ctx) && $stable(cmd_part));

  a_r11_block: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |-> !wr_ready);

  // R10: pulses last one cycle unless a new request is accepted
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_err && !$past(acc) |-> 1'b0);
endmodule

bind demap_decoder demap_decoder_chk #(
  .PAGE_W(VA_W - PAGE_LSB), .CTX_W(CTX_W), .PART_W(PART_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .op_f(wr_addr[OP_LSB +: 2]), .sel_f(wr_addr[CSEL_LSB +: 2]),
  .wr_dside(wr_dside), .cur_part(cur_part),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_page(cmd_page), .cmd_real(cmd_real), .cmd_ctx(cmd_ctx),
  .cmd_part(cmd_part), .req_err(req_err), .req_ignored(req_ignored)
);

// File: tb/demap_decoder_tb.sv
module demap_decoder_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_valid = 0;
  logic        wr_ready;
  logic [63:0] wr_addr = '0;
  logic        wr_dside = 0;
  logic [7:0]  cur_part = '0;
  logic [12:0] pri_ctx = '0;
  logic [12:0] sec_ctx = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1;
  logic [1:0]  cmd_op;
  logic [50:0] cmd_page;
  logic        cmd_real;
  logic [12:0] cmd_ctx;
  logic [7:0]  cmd_part;
  logic        req_err;
  logic        req_ignored;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  demap_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_dside(wr_dside), .cur_part(cur_part),
    .pri_ctx(pri_ctx), .sec_ctx(sec_ctx), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_page(cmd_page),
    .cmd_real(cmd_real), .cmd_ctx(cmd_ctx), .cmd_part(cmd_part),
    .req_err(req_err), .req_ignored(req_ignored)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_addr(input logic [50:0] pg, input bit rb,
                                          input logic [1:0] op, input logic [1:0] sel);
    // junk in bits 12:10, 8 and 3:0 must not matter
    return {pg, 3'b101, rb, 1'b1, op, sel, 4'hA};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(!cmd_valid && !req_err && !req_ignored && wr_ready, "R10", "reset state",
          {60'd0, cmd_valid, req_err, req_ignored, wr_ready}, 64'h1);
    rst_n = 1;
    @(negedge clk);

    for (int side = 0; side < 2; side++)
      for (int op = 0; op < 4; op++)
        for (int sel = 0; sel < 4; sel++)
          for (int rb = 0; rb < 2; rb++) begin
            int idx = ((side * 4 + op) * 4 + sel) * 2 + rb;
            logic [50:0] pg = (51'(idx) * 51'h1_2345_6789) ^ 51'h5_A5A5_0F0F_3C3C;
            logic [12:0] pc = 13'h0A5 + 13'(idx);
            logic [12:0] sc = 13'h1C3 ^ 13'(idx * 7);
            logic [7:0]  pt = 8'(idx) ^ 8'h3C;
            bit ctx_ok; logic [12:0] cv;
            bit ev, ee, ei; logic [50:0] ep; bit er; logic [12:0] ec;
            string tag;
            ctx_ok = (sel == 0) || (sel == 3) || (sel == 1 && side == 1);
            cv = (sel == 0) ? pc : (sel == 1 && side == 1) ? sc : 13'd0;
            ev = 0; ee = 0; ei = 0; ep = '0; er = 0; ec = '0;
            if (op == 3) begin ee = 1; tag = "R6"; end
            else if (op == 2) begin ev = 1; tag = "R5"; end
            else if (!ctx_ok) begin
              ei = 1;
              tag = (sel == 2) ? "R3" : "R2";
            end else begin
              ev = 1; ec = cv;
              if (op == 0) begin ep = pg; er = rb[0]; tag = "R7"; end
              else tag = (sel == 1) ? "R2" : "R1";
            end

            wr_dside = side[0]; pri_ctx = pc; sec_ctx = sc; cur_part = pt;
            wr_addr = mk_addr(pg, rb[0], op[1:0], sel[1:0]);
            wr_valid = 1;
            @(negedge clk);
            wr_valid = 0;
            cur_part = ~pt;
            check(cmd_valid == ev && req_err == ee && req_ignored == ei, tag,
                  "status v/err/ign (R9)", {61'd0, cmd_valid, req_err, req_ignored},
                  {61'd0, ev, ee, ei});
            if (ev)
              check(cmd_op == op[1:0] && cmd_page == ep && cmd_real == er &&
                    cmd_ctx == ec && cmd_part == pt, tag, "fields R4/R8",
                    {cmd_op, cmd_page[36:0], cmd_real, cmd_ctx, cmd_part},
                    {op[1:0], ep[36:0], er, ec, pt});
            @(negedge clk);
            check(!cmd_valid && !req_err && !req_ignored, "R10", "one-cycle pulse",
                  {61'd0, cmd_valid, req_err, req_ignored}, 64'd0);
          end

    // R11 back-pressure with drain and refill in one cycle
    cmd_ready = 0;
    wr_dside = 1; pri_ctx = 13'h123; cur_part = 8'h11;
    wr_addr = mk_addr(51'h7_0000_0000_0001, 1'b1, 2'd0, 2'd0);
    wr_valid = 1;
    @(negedge clk);
    wr_addr = mk_addr(51'h3, 1'b1, 2'd2, 2'd2);
    check(cmd_valid && !wr_ready && cmd_op == 2'd0 && cmd_ctx == 13'h123 &&
          cmd_page == 51'h7_0000_0000_0001, "R11", "stalled cmd",
          {cmd_valid, wr_ready, cmd_op, cmd_ctx, cmd_page[47:0]},
          {1'b1, 1'b0, 2'd0, 13'h123, 48'h0000_0000_0001});
    @(negedge clk);
    check(cmd_valid && !wr_ready && cmd_op == 2'd0 && cmd_part == 8'h11 && cmd_real,
          "R11", "held stable", {56'd0, cmd_part}, 64'h11);
    cur_part = 8'h77;
    cmd_ready = 1;
    @(negedge clk);
    wr_valid = 0;
    check(cmd_valid && cmd_op == 2'd2 && cmd_part == 8'h77 && cmd_ctx == 0 &&
          cmd_page == 0 && !cmd_real, "R11", "refill on drain (R5 R8)",
          {cmd_valid, cmd_op, 53'd0, cmd_part}, {1'b1, 2'd2, 53'd0, 8'h77});
    @(negedge clk);
    check(!cmd_valid && wr_ready, "R11", "slot empty", {62'd0, cmd_valid, wr_ready}, 64'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule